// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block collects six single-cycle link and autonegotiation event strobes into a sticky flag register. It qualifies them with a mask register and raises one active-high interrupt line while any enabled flag is pending. Both registers sit on a simple management register port. The flag register is read-only. The mask register can be read and written.

Software services the interrupt by reading the flag register. That read returns the pending events and clears them in the same access, so no separate acknowledge write is needed. Flags are recorded whether or not their source is enabled. An event that lands in the same cycle as the clearing read is not lost: it appears on the next read.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset both registers read zero and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets flag bit k+1. The flag bits are: bit 1 page received, bit 2 parallel-detection fault, bit 3 partner acknowledge, bit 4 link down, bit 5 remote fault, bit 6 autonegotiation complete.
- R3: Flag bits are sticky. Each bit stays set until the flag register is read, whatever the mask holds.
- R4: While `rd_i` is high with `addr_i` = 29, `rdata_o` shows the current flags. The flags are cleared at the following clock edge.
- R5: An event strobed in the same cycle as the clearing read is kept set for the next read.
- R6: The mask register at `addr_i` = 30 stores bits 6:1 of a write. Its other bits read zero and ignore writes.
- R7: `irq_o` is high exactly when some bit in 6:1 is set in both the flag register and the mask register. A zero mask keeps it low.
- R8: Reads of any other address, or cycles with `rd_i` low, return zero on `rdata_o`. Writes to the flag register or to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event strobes: [0] page rx, [1] parallel fault, [2] partner ack, [3] link down, [4] remote fault, [5] aneg complete |
| addr_i | input | 5 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while `rd_i` is high |
| irq_o | output | 1 | Interrupt, active high |

## Verification
Corrupted flag state appears on `irq_o` in the same cycle if that bit is enabled. Otherwise it appears in the value returned by the next read of address 29. A clear that is lost shows up on the read that follows. A lost same-cycle event shows up as a missing bit on that read. A corrupted mask shows on `irq_o` as soon as a flag is pending, and it also reads back directly at address 30. The reference model is compared on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int NUM_EVT   = 6,
  parameter int EVT_LSB   = 1,
  parameter int FLAG_ADDR = 29,
  parameter int MASK_ADDR = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int HI_PAD = DATA_W - NUM_EVT - EVT_LSB;
  localparam logic [DATA_W-1:0] SRC_BITS =
    DATA_W'(((1 << NUM_EVT) - 1) << EVT_LSB);

  logic [DATA_W-1:0] flag_q, mask_q, evt_w;
  logic flag_sel, mask_sel;

  assign flag_sel = addr_i == ADDR_W'(FLAG_ADDR);
  assign mask_sel = addr_i == ADDR_W'(MASK_ADDR);
  assign evt_w    = {{HI_PAD{1'b0}}, evt_i, {EVT_LSB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= ((rd_i && flag_sel) ? '0 : flag_q) | evt_w;
      if (wr_i && mask_sel)
        mask_q <= wdata_i & SRC_BITS;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && flag_sel) rdata_o = flag_q;
    else if (rd_i && mask_sel) rdata_o = mask_q;
  end

  assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/phy_irq_ctrl_chk.sv
module phy_irq_ctrl_chk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int NUM_EVT   = 6,
  parameter int EVT_LSB   = 1,
  parameter int FLAG_ADDR = 29,
  parameter int MASK_ADDR = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [DATA_W-1:0]  flag_q,
  input logic [DATA_W-1:0]  mask_q
);
  logic rd_flag;
  assign rd_flag = rd_i && addr_i == ADDR_W'(FLAG_ADDR);

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> (flag_q[EVT_LSB +: NUM_EVT] & $past(evt_i)) == $past(evt_i));
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_flag |=> (flag_q & $past(flag_q)) == $past(flag_q));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && evt_i == '0) |=> flag_q == '0);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADDR_W'(MASK_ADDR)) |=> $stable(mask_q));
  // R6
  rdata_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[EVT_LSB-1:0] == '0 && rdata_o[DATA_W-1:EVT_LSB+NUM_EVT] == '0);
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |-> !irq_o);
endmodule

bind phy_irq_ctrl phy_irq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .EVT_LSB(EVT_LSB),
  .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i), .rd_i(rd_i),
  .wr_i(wr_i), .rdata_o(rdata_o), .irq_o(irq_o), .flag_q(flag_q),
  .mask_q(mask_q)
);

// File: tb/phy_irq_ctrl_tb_top.sv
module phy_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt_i = '0;
  logic [4:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int vectors = 0, fails = 0;
  int m_flag = 0, m_mask = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic step(input string req, input int evt, input bit rd, input bit wr,
                      input int addr, input int wd);
    int exp_rd;
    bit exp_irq;
    evt_i = 6'(evt); rd_i = rd; wr_i = wr; addr_i = 5'(addr); wdata_i = 16'(wd);
    #1;
    exp_rd = !rd ? 0 : (addr == 29) ? m_flag : (addr == 30) ? m_mask : 0;
    exp_irq = (m_flag & m_mask) != 0;
    vectors++;
    if (int'(rdata_o) != exp_rd || irq_o != exp_irq) begin
      fails++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               req, rdata_o, irq_o, exp_rd[15:0], exp_irq);
    end
    @(posedge clk);
    if (rd && addr == 29) m_flag = 0;
    m_flag |= evt << 1;
    if (wr && addr == 30) m_mask = wd & 'h7E;
    @(negedge clk);
  endtask

  initial begin
    #500us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lfsr = 'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 1, 0, 29, 0);
    step("R1", 0, 1, 0, 30, 0);
    for (int k = 0; k < 6; k++) begin
      step("R2", 1 << k, 0, 0, 0, 0);
      step("R2", 0, 1, 0, 29, 0);
      step("R4", 0, 1, 0, 29, 0);
    end
    step("R3", 'h09, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0);
    step("R3", 'h10, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 30, 'hFFFF);
    step("R6", 0, 1, 0, 30, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 30, 'h0040);
    step("R7", 0, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 29, 0);
    step("R5", 'h20, 1, 0, 29, 0);
    step("R5", 0, 1, 0, 29, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R8", 'h01, 0, 1, 29, 'hFFFF);
    step("R8", 0, 1, 0, 0, 0);
    step("R8", 0, 1, 0, 31, 0);
    step("R8", 0, 0, 1, 5, 'hFFFF);
    step("R8", 0, 1, 0, 29, 0);
    step("R8", 0, 1, 0, 30, 0);
    step("R7", 0, 0, 1, 30, 0);
    step("R7", 'h3F, 0, 0, 0, 0);
    step("R7", 0, 1, 0, 29, 0);
    for (int i = 0; i < 400; i++) begin
      int a;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0);
      a = (lfsr[3:2] == 0) ? 29 : (lfsr[3:2] == 1) ? 30 : lfsr[8:4];
      step("R7", (lfsr[15:14] == 0) ? (lfsr >> 6) & 'h3F : 0, lfsr[0], lfsr[1] & lfsr[12],
           a, lfsr);
    end
    rst_n = 1'b0;
    m_flag = 0; m_mask = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 1, 0, 30, 0);
    step("R1", 0, 1, 0, 29, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule